// File: doc/BRIEF.md
# Dual-Edge Serial Word Deserializer

This block takes one fast serial data line and a bit clock that runs at half the bit rate. It samples the line on both edges of that clock: the rising-edge sample of each clock period is the earlier bit and the falling-edge sample is the later one. Each edge has its own plain flip-flop shift chain. The falling-edge chain is carried into the rising-edge domain through one register stage. The two streams are then merged into 12-bit words, so each word holds six bits from each edge.

A framing counter in the rising-edge domain marks one word boundary every six clock periods. At that boundary it registers the merged word and raises a valid strobe for exactly one cycle. A single-cycle bit-slip pulse moves the word boundary one serial bit later. A bit-slip pulse swaps which edge leads each word, and every second slip also stretches one word interval by a cycle.

The reset is synchronous and active high. It restarts the framing logic and clears the output register. The serial capture chains have no reset input.

Top module: `ddr_deser`

## Requirements
- R1: `word_valid` is high for exactly one cycle at a time. With no bit-slip, successive strobes are exactly 6 rising edges apart.
- R2: In the default pairing, within each clock period the rising-edge sample comes before the falling-edge sample in serial order. The earliest serial bit of a word sits in `word_out[11]` and the latest in `word_out[0]`, and the word bits alternate between rising and falling samples.
- R3: If rising edge r is the first one that samples `rst` low, the first strobe is registered at edge r+5. Its word ends with the falling-edge sample taken in the clock period that starts at edge r+3.
- R4: While `rst` is sampled high, `word_valid` and `word_out` are zero. Reset restores the rising-first pairing and restarts the framing count. The serial capture chains are not cleared, so the first word after reset may hold bits received while reset was high.
- R5: A bit-slip pulse taken in rising-first pairing moves the boundary one serial bit later. The next strobe follows the previous one after 7 edges, and later words begin with a falling-edge sample.
- R6: A bit-slip pulse taken in falling-first pairing restores rising-first pairing and moves the boundary one more serial bit later. The strobe interval stays 6 edges.
- R7: Between strobes, `word_out` holds the last registered word (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock at half the bit rate; both edges sample `ser_in` |
| rst | input | 1 | Synchronous active-high reset for the framing and output logic |
| ser_in | input | 1 | Serial data line |
| bit_slip | input | 1 | Single-cycle pulse that shifts the word boundary by one bit |
| word_out | output | 12 | Recovered parallel word, earliest bit in the MSB |
| word_valid | output | 1 | One-cycle strobe marking a new `word_out` |

## Verification
The checks on strobe spacing assume that `bit_slip` is only ever a single-cycle pulse, and that it is never sampled at an edge where a strobe is being registered. If that were allowed, a held counter could register two strobes in a row. The stimulus raises `bit_slip` just after a strobe appears and drops it after one edge, so each slip lands at the start of a word interval. The serial line changes a quarter period after each clock edge, so every sample the bench predicts is stable at both capture edges.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

    localparam int unsigned DEF_WORD_W = 12;

    // Which edge supplies the earliest bit of a word.
    typedef enum logic {
        PAIR_RISE_LEAD = 1'b0,
        PAIR_FALL_LEAD = 1'b1
    } pair_e;

    // Framing state presented to the output stage.
    typedef struct packed {
        logic  boundary;
        pair_e pairing;
    } frame_s;

    function automatic pair_e other_pair(input pair_e p);
        return (p == PAIR_RISE_LEAD) ? PAIR_FALL_LEAD : PAIR_RISE_LEAD;
    endfunction

endpackage

// File: rtl/ddr_deser_edge_chain.sv
// Plain shift chain on one clock edge: no reset, no logic between stages.
module ddr_deser_edge_chain #(
    parameter int unsigned DEPTH   = 6,
    parameter bit          FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk) begin
                taps <= {taps[DEPTH-2:0], din};
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                taps <= {taps[DEPTH-2:0], din};
            end
        end
    endgenerate

endmodule

// File: rtl/ddr_deser_merge.sv
// Interleaves the retimed edge streams into one word for either pairing.
module ddr_deser_merge
    import ddr_deser_pkg::*;
#(
    parameter int unsigned HALF_W = 6
) (
    input  pair_e                 pairing,
    input  logic [HALF_W-1:0]     rise_d,
    input  logic [HALF_W:0]       fall_d,
    output logic [2*HALF_W-1:0]   word
);

    logic [2*HALF_W-1:0] w_rise_lead;
    logic [2*HALF_W-1:0] w_fall_lead;

    generate
        for (genvar i = 0; i < HALF_W; i++) begin : g_bit
            // rise sample precedes the fall sample of the same period
            assign w_rise_lead[2*i+1] = rise_d[i];
            assign w_rise_lead[2*i]   = fall_d[i];
            // fall sample of the previous period precedes the rise sample
            assign w_fall_lead[2*i+1] = fall_d[i+1];
            assign w_fall_lead[2*i]   = rise_d[i];
        end
    endgenerate

    assign word = (pairing == PAIR_FALL_LEAD) ? w_fall_lead : w_rise_lead;

endmodule

// File: rtl/ddr_deser_framer.sv
// Word boundary counter and edge pairing state, rising-edge domain.
module ddr_deser_framer
    import ddr_deser_pkg::*;
#(
    parameter int unsigned HALF_W = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   slip,
    output frame_s frame
);

    localparam int unsigned CNT_W = (HALF_W > 1) ? $clog2(HALF_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_W - 1);

    logic [CNT_W-1:0] cnt;
    pair_e            pairing;
    logic             hold;

    // Leaving rising-first pairing costs one extra bit: stall one cycle.
    assign hold = slip && (pairing == PAIR_RISE_LEAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pairing <= PAIR_RISE_LEAD;
        end else begin
            if (slip) begin
                pairing <= other_pair(pairing);
            end
            if (!hold) begin
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign frame.boundary = (cnt == LAST);
    assign frame.pairing  = pairing;

endmodule

// File: rtl/ddr_deser.sv
module ddr_deser
    import ddr_deser_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              bit_slip,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int unsigned HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] rise_taps;
    logic [HALF_W:0]   fall_taps;
    logic [HALF_W-1:0] rise_q;
    logic [HALF_W:0]   fall_q;
    logic [WORD_W-1:0] merged;
    frame_s            frame;

    ddr_deser_edge_chain #(.DEPTH(HALF_W), .FALLING(1'b0)) u_rise_chain (
        .clk  (clk),
        .din  (ser_in),
        .taps (rise_taps)
    );

    // One extra stage so the falling-first pairing reaches a full word.
    ddr_deser_edge_chain #(.DEPTH(HALF_W + 1), .FALLING(1'b1)) u_fall_chain (
        .clk  (clk),
        .din  (ser_in),
        .taps (fall_taps)
    );

    // Move both streams onto the rising edge, aligned by clock period.
    always_ff @(posedge clk) begin
        rise_q <= rise_taps;
        fall_q <= fall_taps;
    end

    ddr_deser_framer #(.HALF_W(HALF_W)) u_framer (
        .clk   (clk),
        .rst   (rst),
        .slip  (bit_slip),
        .frame (frame)
    );

    ddr_deser_merge #(.HALF_W(HALF_W)) u_merge (
        .pairing (frame.pairing),
        .rise_d  (rise_q),
        .fall_d  (fall_q),
        .word    (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= frame.boundary;
            if (frame.boundary) begin
                word_out <= merged;
            end
        end
    end

endmodule

// File: rtl/ddr_deser_chk.sv
module ddr_deser_chk #(
    parameter int unsigned WORD_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_slip,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_out
);

    localparam int unsigned HALF_W = WORD_W / 2;

    logic [7:0] gap;
    logic       seen;
    logic       slip_pend;

    // Cycles since the last strobe, and whether a slip happened in between.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            seen      <= 1'b0;
            slip_pend <= 1'b0;
        end else if (word_valid) begin
            gap       <= 8'd1;
            seen      <= 1'b1;
            slip_pend <= bit_slip;
        end else begin
            if (gap != 8'hFF) gap <= gap + 8'd1;
            slip_pend <= slip_pend | bit_slip;
        end
    end

    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    assert_cadence_R1: assert property (@(posedge clk) disable iff (rst)
        (word_valid && seen && !slip_pend) |-> (gap == 8'(HALF_W)));

    assert_slip_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (word_valid && seen && slip_pend) |->
            (gap == 8'(HALF_W) || gap == 8'(HALF_W + 1)));

    assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));

    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> (!word_valid && word_out == '0));

endmodule

bind ddr_deser ddr_deser_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_slip   (bit_slip),
    .word_valid (word_valid),
    .word_out   (word_out)
);

// File: tb/ddr_deser_tb.sv
module ddr_deser_tb;

    localparam int WORD_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ser_in = 1'b0;
    logic              bit_slip = 1'b0;
    logic [WORD_W-1:0] word_out;
    logic              word_valid;

    always #10 clk = ~clk;

    ddr_deser #(.WORD_W(WORD_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .bit_slip   (bit_slip),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    bit          hist [0:4095];
    int          nbit = 0;
    int          pat_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Monitor / model state
    int                cyc = 0;
    bit                in_rst = 1'b1;
    int                rel_j = 0;
    int                next_v = 0;
    int                end_idx = 0;
    bit                even = 1'b1;
    logic [WORD_W-1:0] last_word = '0;
    int                nwords = 0;
    int                last_v_cyc = 0;
    bit                first_pending = 1'b0;
    string             wtag = "R2";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_bit();
        bit b;
        case (pat_mode)
            0: b = (nbit % 2 == 1);
            1: begin
                b = lfsr[0];
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
            2: b = (nbit % 13 == 0);
            default: b = 1'b1;
        endcase
        hist[nbit % 4096] = b;
        ser_in = b;
        nbit++;
    endtask

    // Serial driver: line changes a quarter period after each edge.
    initial begin
        push_bit();
        forever begin
            @(posedge clk);
            #5 push_bit();
            @(negedge clk);
            #5 push_bit();
        end
    end

    // Monitor with independent model of framing and bit positions.
    initial begin
        forever begin
            int j;
            @(posedge clk);
            #2;
            j = cyc;
            cyc++;
            if (rst) begin
                in_rst = 1'b1;
                last_word = '0;
            end else begin
                if (in_rst) begin
                    in_rst = 1'b0;
                    rel_j = j;
                    next_v = j + 5;
                    end_idx = 2 * j + 7;
                    even = 1'b1;
                    first_pending = 1'b1;
                end
                if (j == next_v) begin
                    logic [WORD_W-1:0] exp;
                    for (int i = 0; i < WORD_W; i++)
                        exp[WORD_W-1-i] = hist[(end_idx - (WORD_W - 1) + i) % 4096];
                    check(word_valid === 1'b1, first_pending ? "R3" : "R1",
                          "strobe missing", {11'd0, word_valid}, 12'd1);
                    check(word_out === exp, first_pending ? "R3" : wtag,
                          "word content", word_out, exp);
                    last_word = word_out;
                    last_v_cyc = j;
                    nwords++;
                    first_pending = 1'b0;
                    next_v += 6;
                    end_idx += 12;
                end else begin
                    check(word_valid === 1'b0, "R1", "unexpected strobe",
                          {11'd0, word_valid}, 12'd0);
                    check(word_out === last_word, "R7", "word not held",
                          word_out, last_word);
                end
                if (bit_slip) begin
                    end_idx += 1;
                    if (even) next_v += 1;
                    even = !even;
                end
            end
        end
    end

    task automatic wait_words(input int n);
        int target;
        target = nwords + n;
        while (nwords < target) @(posedge clk);
        #3;
    endtask

    task automatic t_reset_state();
        repeat (3) @(posedge clk);
        #4;
        check(word_valid === 1'b0, "R4", "valid in reset", {11'd0, word_valid}, 12'd0);
        check(word_out === '0, "R4", "word in reset", word_out, 12'd0);
        @(posedge clk);
        #5 rst = 1'b0;
    endtask

    task automatic t_first_word();
        wait_words(1);
        check(last_v_cyc == rel_j + 5, "R3", "first strobe edge",
              12'(last_v_cyc - rel_j), 12'd5);
    endtask

    task automatic t_pattern(input int mode, input string tag, input int n);
        int c0;
        pat_mode = mode;
        wtag = tag;
        wait_words(1);
        c0 = last_v_cyc;
        wait_words(n - 1);
        check(last_v_cyc - c0 == 6 * (n - 1), "R1", "strobe cadence",
              12'(last_v_cyc - c0), 12'(6 * (n - 1)));
    endtask

    task automatic t_slip(input string tag, input int exp_gap);
        int v0;
        do begin
            @(posedge clk);
            #3;
        end while (!word_valid);
        v0 = last_v_cyc;
        bit_slip = 1'b1;
        @(posedge clk);
        #3 bit_slip = 1'b0;
        wtag = tag;
        wait_words(1);
        check(last_v_cyc - v0 == exp_gap, tag, "interval after slip",
              12'(last_v_cyc - v0), 12'(exp_gap));
        wait_words(3);
    endtask

    task automatic t_midreset();
        int w0;
        t_slip("R5", 7);
        pat_mode = 1;
        repeat (4) @(posedge clk);
        #5 rst = 1'b1;
        repeat (2) @(posedge clk);
        #4;
        check(word_valid === 1'b0, "R4", "valid in mid reset", {11'd0, word_valid}, 12'd0);
        check(word_out === '0, "R4", "word in mid reset", word_out, 12'd0);
        @(posedge clk);
        #5 rst = 1'b0;
        wtag = "R4";
        w0 = nwords;
        wait_words(1);
        check(last_v_cyc == rel_j + 5, "R4", "restart strobe edge",
              12'(last_v_cyc - rel_j), 12'd5);
        wait_words(2);
        check(nwords - w0 == 3, "R4", "words after reset", 12'(nwords - w0), 12'd3);
    endtask

    initial begin
        t_reset_state();
        t_first_word();
        t_pattern(0, "R2", 5);
        t_pattern(1, "R2", 8);
        t_pattern(2, "R2", 6);
        t_pattern(1, "R2", 4);
        t_slip("R5", 7);
        t_pattern(1, "R5", 4);
        t_slip("R6", 6);
        t_pattern(1, "R6", 4);
        t_midreset();
        t_pattern(3, "R2", 3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule